// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is a programmable logic cell. It takes a 24-bit input bus and forms product terms in an AND plane. Each term is an AND of any chosen true or inverted input literals. Two OR/XOR planes turn those terms into eight outputs, four per plane. Each output picks one of several logic paths, and the result is either passed straight through or held in a flip-flop.

Three more product terms are reserved for control. The first acts as a clock enable for the registers, the second clears the registers, and the third is exported as an output-enable signal.

All programming sits in one configuration register that is loaded serially before use. While the register is loading, and until loading has finished, every output is held at 0. The cell runs on a single system clock `clk`. Each of the three global clock inputs is an enable strobe sampled on that clock.

Top module: `ptl_logic_cell`

## Requirements
- R1: Term t has two mask fields inside the AND area, which starts at bit 0 and gives each term 48 bits (base t*48). Field bit i (bits base+0..base+23) requires `din[i]`=1. Field bit 24+i requires `din[i]`=0. A term with no mask bit set is 0, and so is a term that asks for both literals of one input. Terms 0..19 are logic terms, term 20 is the clock term, term 21 is the clear term and term 22 is the enable term.
- R2: Mode 0 (bypass): the output is the OR of terms 4k..4k+3, where k = output index mod 4. Polarity is not applied.
- R3: Mode 1: the output is term 4k XOR the polarity bit.
- R4: Modes 2 and 3: the output is the OR of all logic terms selected by the output's 20-bit OR mask, XOR the polarity bit. The OR mask of output o sits at bit 1104+20*o, and mask bit j selects term j.
- R5: Each output has a 6-bit control field at bit 1264+6*o, laid out as mode[1:0], registered[2], clock select[4:3] and polarity[5]. When registered=0, the output follows its logic value in the same cycle.
- R6: When registered=1 and clock select is 0..2, the flip-flop loads the logic value on a `clk` edge where `gclk_en[sel]` is 1. Otherwise it holds its value.
- R7: Clock select 3 uses the clock term (term 20) as the load enable.
- R8: When the clear term (term 21) is 1 at an edge, every flip-flop goes to 0. This takes priority over a load.
- R9: `grst_n`=0 at an edge clears every flip-flop and marks the configuration invalid. After that, outputs stay 0 until a new load completes.
- R10: While `cfg_en`=1, each edge shifts `cfg_bit` into the top of the 1312-bit register, so the first bit shifted in ends at bit 0. Outputs and `oe_out` read 0 from the first edge with `cfg_en`=1 until the first edge after `cfg_en` returns to 0.
- R11: Once the configuration is valid, `oe_out` equals the enable term (term 22) combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| grst_n | input | 1 | Active-low synchronous global clear |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| din | input | 24 | Input bus into the AND plane |
| gclk_en | input | 3 | Global clock enable strobes |
| dout | output | 8 | Logic outputs |
| oe_out | output | 1 | Exported product-term output enable |

## Verification
The assertions assume that `din`, `gclk_en` and `cfg_en` change only away from the `clk` edge. They also assume that a configuration is not shifted in while registered results are being checked, because the load clears the flip-flops. The stimulus changes every input at the falling edge and never overlaps a load with a register test. Sparse random AND masks keep many terms active, so the OR and XOR paths see both values.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
  typedef enum logic [1:0] {
    M_BYPASS = 2'd0,
    M_SINGLE = 2'd1,
    M_WIDE   = 2'd2,
    M_WIDE_B = 2'd3
  } mode_e;

  typedef struct packed {
    logic       pol;
    logic [1:0] csel;
    logic       reg_en;
    mode_e      mode;
  } out_ctl_t;
endpackage

// File: rtl/ptl_and_plane.sv
module ptl_and_plane #(
  parameter int N_IN   = 24,
  parameter int N_TERM = 23
) (
  input  logic [N_IN-1:0]          din,
  input  logic [N_TERM*2*N_IN-1:0] mask,
  output logic [N_TERM-1:0]        pt
);
  localparam int TW = 2 * N_IN;

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] need_hi, need_lo;
    assign need_hi = mask[t*TW +: N_IN];
    assign need_lo = mask[t*TW+N_IN +: N_IN];
    // empty term is forced low (unused term shutdown)
    assign pt[t] = ((need_hi | need_lo) != '0) &&
                   ((need_hi & ~din) == '0) &&
                   ((need_lo & din) == '0);
  end
endmodule

// File: rtl/ptl_out_path.sv
module ptl_out_path
  import ptl_pkg::*;
#(
  parameter int N_PT = 20,
  parameter int BASE = 0
) (
  input  logic [N_PT-1:0] pt,
  input  logic [N_PT-1:0] or_mask,
  input  mode_e           mode,
  input  logic            pol,
  output logic            res
);
  logic wide_or, fast_or;

  assign wide_or = |(pt & or_mask);
  assign fast_or = |pt[BASE +: 4];

  always_comb begin
    unique case (mode)
      M_BYPASS: res = fast_or;
      M_SINGLE: res = pt[BASE] ^ pol;
      default:  res = wide_or ^ pol;
    endcase
  end
endmodule

// File: rtl/ptl_out_reg.sv
module ptl_out_reg (
  input  logic clk,
  input  logic grst_n,
  input  logic clr,
  input  logic ptrst,
  input  logic ce,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!grst_n || clr || ptrst) q <= 1'b0;
    else if (ce)                 q <= d;
  end

  p_ptclear_r8: assert property (@(posedge clk) disable iff (!grst_n)
    ptrst |=> (q == 1'b0));
  p_hold_r6: assert property (@(posedge clk) disable iff (!grst_n)
    (!clr && !ptrst && !ce) |=> $stable(q));
  p_capture_r6: assert property (@(posedge clk) disable iff (!grst_n)
    (!clr && !ptrst && ce) |=> (q == $past(d)));
endmodule

// File: rtl/ptl_logic_cell.sv
module ptl_logic_cell
  import ptl_pkg::*;
#(
  parameter int N_IN  = 24,
  parameter int N_PT  = 20,
  parameter int N_OUT = 8
) (
  input  logic             clk,
  input  logic             grst_n,
  input  logic             cfg_en,
  input  logic             cfg_bit,
  input  logic [N_IN-1:0]  din,
  input  logic [2:0]       gclk_en,
  output logic [N_OUT-1:0] dout,
  output logic             oe_out
);
  localparam int TERMS   = N_PT + 3;
  localparam int AND_W   = TERMS * 2 * N_IN;
  localparam int OR_W    = N_OUT * N_PT;
  localparam int CTL_W   = $bits(out_ctl_t);
  localparam int CFG_W   = AND_W + OR_W + N_OUT * CTL_W;
  localparam int OUT_GRP = N_OUT / 2;
  localparam int T_CLK   = N_PT;
  localparam int T_CLR   = N_PT + 1;
  localparam int T_OE    = N_PT + 2;

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_ready, load_seen;
  logic [TERMS-1:0] pt;

  always_ff @(posedge clk) begin
    if (cfg_en) cfg_q <= {cfg_bit, cfg_q[CFG_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!grst_n) begin
      cfg_ready <= 1'b0;
      load_seen <= 1'b0;
    end else if (cfg_en) begin
      cfg_ready <= 1'b0;
      load_seen <= 1'b1;
    end else if (load_seen) begin
      cfg_ready <= 1'b1;
    end
  end

  ptl_and_plane #(.N_IN(N_IN), .N_TERM(TERMS)) and_i (
    .din (din),
    .mask(cfg_q[AND_W-1:0]),
    .pt  (pt)
  );

  for (genvar p = 0; p < 2; p++) begin : g_plane
    for (genvar j = 0; j < OUT_GRP; j++) begin : g_out
      localparam int O = p * OUT_GRP + j;
      out_ctl_t ctl;
      logic     d, q, ce;

      assign ctl = out_ctl_t'(cfg_q[AND_W+OR_W+O*CTL_W +: CTL_W]);

      ptl_out_path #(.N_PT(N_PT), .BASE(4*j)) path_i (
        .pt     (pt[N_PT-1:0]),
        .or_mask(cfg_q[AND_W+O*N_PT +: N_PT]),
        .mode   (ctl.mode),
        .pol    (ctl.pol),
        .res    (d)
      );

      always_comb begin
        case (ctl.csel)
          2'd0:    ce = gclk_en[0];
          2'd1:    ce = gclk_en[1];
          2'd2:    ce = gclk_en[2];
          default: ce = pt[T_CLK];
        endcase
      end

      ptl_out_reg reg_i (
        .clk   (clk),
        .grst_n(grst_n),
        .clr   (!cfg_ready),
        .ptrst (pt[T_CLR]),
        .ce    (ce),
        .d     (d),
        .q     (q)
      );

      assign dout[O] = cfg_ready & (ctl.reg_en ? q : d);
    end
  end

  assign oe_out = cfg_ready & pt[T_OE];

  p_dark_load_r10: assert property (@(posedge clk) disable iff (!grst_n)
    cfg_en |=> (dout == '0 && !oe_out));
endmodule

// File: tb/ptl_logic_cell_tb.sv
`timescale 1ns/1ps
module ptl_logic_cell_tb_top;
  localparam int NI = 24, NP = 20, NO = 8;
  localparam int TW = 2 * NI;
  localparam int AW = (NP + 3) * TW;
  localparam int OB = AW;
  localparam int CB = AW + NO * NP;
  localparam int CW = CB + NO * 6;

  localparam logic [23:0] VEC [16] = '{
    24'h000000, 24'hFFFFFF, 24'h000001, 24'h000002,
    24'h000003, 24'hAAAAAA, 24'h555555, 24'h0F0F0F,
    24'hF0F0F0, 24'h123456, 24'hFEDCBA, 24'h800001,
    24'h7FFFFE, 24'h00FF00, 24'hC3C3C3, 24'h3C5A96
  };

  logic clk = 0, grst_n = 0, cfg_en = 0, cfg_bit = 0;
  logic [NI-1:0] din = '0;
  logic [2:0] gclk_en = '0;
  logic [NO-1:0] dout;
  logic oe_out;
  logic [CW-1:0] cv;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptl_logic_cell dut_i (.clk(clk), .grst_n(grst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .din(din), .gclk_en(gclk_en), .dout(dout), .oe_out(oe_out));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic m_pt(int t, logic [23:0] x);
    logic [23:0] hi, lo;
    hi = cv[t*TW +: 24];
    lo = cv[t*TW+24 +: 24];
    if ((hi | lo) == 0) return 1'b0;
    for (int i = 0; i < 24; i++) begin
      if (hi[i] && !x[i]) return 1'b0;
      if (lo[i] && x[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic m_out(int o, logic [23:0] x);
    logic [5:0] c;
    logic acc;
    int k;
    c = cv[CB+o*6 +: 6];
    k = (o % 4) * 4;
    if (c[1:0] == 2'd0) return m_pt(k, x) | m_pt(k+1, x) | m_pt(k+2, x) | m_pt(k+3, x);
    if (c[1:0] == 2'd1) return m_pt(k, x) ^ c[5];
    acc = 1'b0;
    for (int j = 0; j < NP; j++) if (cv[OB+o*NP+j]) acc |= m_pt(j, x);
    return acc ^ c[5];
  endfunction

  task automatic load_cfg();
    for (int i = 0; i < CW; i++) begin
      @(negedge clk);
      cfg_en = 1; cfg_bit = cv[i];
      if (i == 5) begin #1; chk("R10 dark during load", {dout, oe_out}, 0); end
    end
    @(negedge clk);
    cfg_en = 0;
    #1 chk("R10 dark before ready", {dout, oe_out}, 0);
    @(negedge clk);
  endtask

  task automatic set_lit(int t, int i, bit inv);
    cv[t*TW + (inv ? 24 : 0) + i] = 1'b1;
  endtask

  task automatic set_ctl(int o, logic [5:0] c);
    cv[CB+o*6 +: 6] = c;
  endtask

  task automatic walk_table();
    string tg;
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      din = VEC[v];
      #1;
      for (int o = 0; o < NO; o++) begin
        case (cv[CB+o*6 +: 2])
          2'd0: tg = "R2 bypass";
          2'd1: tg = "R3 single term";
          default: tg = "R4 wide sum";
        endcase
        chk({tg, " R5 comb"}, dout[o], m_out(o, VEC[v]));
      end
      chk("R11 oe", oe_out, m_pt(NP+2, VEC[v]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {dout, oe_out}, 0);
    grst_n = 1;
    @(negedge clk);
    chk("R10 unloaded outputs", {dout, oe_out}, 0);

    // directed term semantics (R1)
    cv = '0;
    set_lit(0, 0, 0); set_lit(0, 1, 1);
    set_lit(4, 2, 0); set_lit(4, 2, 1);
    set_lit(NP+2, 21, 0);
    set_ctl(0, 6'b000001); set_ctl(1, 6'b100001); set_ctl(2, 6'b000001);
    load_cfg();
    din = 24'h000001; #1;
    chk("R1 literal pair true", dout[0], 1'b1);
    chk("R1 contradictory term", dout[1], 1'b1);
    chk("R1 empty term", dout[2], 1'b0);
    @(negedge clk); din = 24'h000007; #1;
    chk("R1 inverted literal", dout[0], 1'b0);
    chk("R1 both literals of one input", dout[1], 1'b1);
    walk_table();

    // random configurations, combinational outputs
    for (int r = 0; r < 4; r++) begin
      cv = '0;
      for (int t = 0; t < NP + 3; t++) begin
        int n = 1 + $urandom % 3;
        for (int l = 0; l < n; l++) set_lit(t, $urandom % 24, $urandom % 2);
      end
      for (int b = 0; b < NO * NP; b++) cv[OB+b] = ($urandom % 3 == 0);
      for (int o = 0; o < NO; o++) set_ctl(o, {1'($urandom % 2), 2'b00, 1'b0, 2'($urandom % 4)});
      load_cfg();
      walk_table();
    end

    // registered outputs: d = din[0]; clock term din[22]; clear term din[23]; oe din[21]
    cv = '0;
    set_lit(16, 0, 0);
    set_lit(NP, 22, 0); set_lit(NP+1, 23, 0); set_lit(NP+2, 21, 0);
    for (int o = 0; o < NO; o++) begin
      cv[OB+o*NP+16] = 1'b1;
      set_ctl(o, {1'b0, 2'(o % 4), 1'b1, 2'd2});
    end
    load_cfg();
    din = 24'h000001; gclk_en = 3'b000;
    @(negedge clk); #1;
    chk("R6 hold with no enable", dout, 8'h00);
    gclk_en = 3'b001;
    @(negedge clk); #1;
    chk("R6 load on gclk 0", dout, 8'h11);
    gclk_en = 3'b000; din = 24'h000000;
    @(negedge clk); #1;
    chk("R6 hold after input change", dout, 8'h11);
    din = 24'h600001;
    #1 chk("R11 oe from term", oe_out, 1'b1);
    @(negedge clk); #1;
    chk("R7 load on clock term", dout, 8'h99);
    din = 24'h800001; gclk_en = 3'b111;
    @(negedge clk); #1;
    chk("R8 clear term wins", dout, 8'h00);
    din = 24'h400001;
    @(negedge clk); #1;
    chk("R6 load on all enables", dout, 8'hFF);
    grst_n = 0;
    @(negedge clk); #1;
    chk("R9 global clear", {dout, oe_out}, 0);
    grst_n = 1;
    @(negedge clk); @(negedge clk); #1;
    chk("R9 config invalid after clear", {dout, oe_out}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule